// File: doc/BRIEF.md
# Serial Flash Status and Identification Responder

This block is the target-side command logic of a serial flash that answers status polling and identification requests over a four-wire SPI link in clock mode 0 or 3. All logic runs on one system clock. The serial clock, chip select and data input arrive already synchronised, and the block finds their edges internally. After chip select goes low, the block takes an 8-bit instruction most-significant bit first, sampling the data input on rising serial-clock edges. Reply data changes on falling edges, so the master can sample it on the next rising edge.

The block holds a small status register with four fields: a busy flag, a write-enable latch, three block-protect bits and a status-write-disable bit. Two single-cycle sideband requests stand in for the memory array. One starts a program or erase cycle. The other starts a status-write cycle carrying new protect bits. A stub counter holds the busy flag high for a fixed number of clocks, then releases it. The status can be polled continuously in one transaction, and each repeated byte shows the busy flag as it stands when that byte begins.

Top module: `sflash_stat_id_resp`

## Requirements
- R1: After reset, the data-output enable is low and the status byte reads 0x00.
- R2: Opcode 0x05 returns the status byte MSB first. Bit 0 is busy, bit 1 is the write-enable latch, bits 4:2 are the protect bits (bit 4 is the most significant), bits 6:5 read as 0, and bit 7 is the status-write-disable bit.
- R3: After opcode 0x05, the status byte repeats for as long as chip select stays low. Each byte is captured at its first output bit, so the busy flag can change between bytes of one transaction.
- R4: Opcode 0x9F returns the 8-bit manufacturer code, then the 16-bit device code, MSB first, and 0 bits after that.
- R5: The output enable stays low while the instruction is shifted in, and within one clock after chip select goes high.
- R6: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Either takes effect only if chip select rises after exactly 8 rising serial-clock edges.
- R7: Any other opcode gives no output and no status change until chip select rises.
- R8: A program/erase or status-write request is accepted only while the latch is 1 and busy is 0. Any other request is ignored.
- R9: An accepted request holds busy high for BUSY_CYC clocks. When busy ends, the latch clears and a status-write request loads its protect and write-disable bits (sr_wdata[3] is the write-disable bit, sr_wdata[2:0] are the protect bits).
- R10: Chip select going high at any point ends the transaction, and the next transaction starts with a new instruction.
- R11: The data output changes only on falling serial-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, synchronised |
| cs_n | input | 1 | Chip select, active low, synchronised |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output driver enable; low means high impedance at the pad |
| wr_req | input | 1 | Pulse: start a program/erase cycle |
| sr_req | input | 1 | Pulse: start a status-write cycle |
| sr_wdata | input | 4 | New write-disable bit and protect bits for a status write |

## Verification
The bench polls the status without a break while a busy cycle expires. A design that captured status only once per transaction would keep reporting busy; a design that sampled it bit by bit would return a torn byte. Latch commands are sent with 7 and with 9 clocks, which catches a design that acts on a short or overlong frame. A second request is issued during busy, which catches a design that lets a later request overwrite the pending protect bits. An aborted read followed by an identification read catches a shifter that is not returned to the instruction phase.

// File: rtl/sflash_stat_id_resp.sv
module sflash_stat_id_resp #(
  parameter logic [7:0]  MFR_ID   = 8'h20,
  parameter logic [15:0] DEV_ID   = 16'h2013,
  parameter int          BUSY_CYC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       miso,
  output logic       miso_oe,
  input  logic       wr_req,
  input  logic       sr_req,
  input  logic [3:0] sr_wdata
);
  localparam int BW = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;
  localparam logic [7:0] OP_STAT = 8'h05;
  localparam logic [7:0] OP_ID   = 8'h9F;
  localparam logic [7:0] OP_WEN  = 8'h06;
  localparam logic [7:0] OP_WDIS = 8'h04;

  typedef enum logic [2:0] {PH_CMD, PH_STAT, PH_ID, PH_WAIT, PH_IGN} ph_t;

  ph_t         ph;
  logic        sclk_d, cs_d;
  logic [2:0]  bcnt, ocnt;
  logic [6:0]  ishift;
  logic [23:0] osh;
  logic        dout, oe, wen_op;
  logic        wip, wel, srwd, pend_sr;
  logic [2:0]  bp;
  logic [3:0]  pend_val;
  logic [BW-1:0] busy_cnt;

  wire       sck_rise = !cs_n && sclk && !sclk_d;
  wire       sck_fall = !cs_n && !sclk && sclk_d;
  wire       cs_up    = cs_n && !cs_d;
  wire [7:0] opcode   = {ishift, mosi};
  wire [7:0] stat     = {srwd, 2'b00, bp, wel, wip};
  wire       data_ph  = (ph == PH_STAT) || (ph == PH_ID);
  wire       accept   = !wip && wel && (wr_req || sr_req);

  assign miso    = oe ? dout : 1'b0;
  assign miso_oe = oe;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk;
      cs_d   <= cs_n;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph     <= PH_CMD;
      bcnt   <= '0;
      ocnt   <= '0;
      ishift <= '0;
      osh    <= '0;
      dout   <= 1'b0;
      oe     <= 1'b0;
      wen_op <= 1'b0;
    end else if (cs_n) begin
      ph   <= PH_CMD;
      bcnt <= '0;
      ocnt <= '0;
      oe   <= 1'b0;
    end else begin
      if (sck_rise)
        case (ph)
          PH_CMD: begin
            ishift <= opcode[6:0];
            bcnt   <= bcnt + 3'd1;
            if (bcnt == 3'd7)
              case (opcode)
                OP_STAT: ph <= PH_STAT;
                OP_ID:   ph <= PH_ID;
                OP_WEN:  begin ph <= PH_WAIT; wen_op <= 1'b1; end
                OP_WDIS: begin ph <= PH_WAIT; wen_op <= 1'b0; end
                default: ph <= PH_IGN;
              endcase
          end
          PH_WAIT: ph <= PH_IGN;
          default: ;
        endcase
      if (sck_fall && data_ph) begin
        oe   <= 1'b1;
        ocnt <= ocnt + 3'd1;
        if (ph == PH_STAT && ocnt == 3'd0) begin
          dout <= stat[7];
          osh  <= {stat[6:0], 17'd0};
        end else if (ph == PH_ID && !oe) begin
          dout <= MFR_ID[7];
          osh  <= {MFR_ID[6:0], DEV_ID, 1'b0};
        end else begin
          dout <= osh[23];
          osh  <= {osh[22:0], 1'b0};
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wip      <= 1'b0;
      wel      <= 1'b0;
      srwd     <= 1'b0;
      bp       <= '0;
      pend_sr  <= 1'b0;
      pend_val <= '0;
      busy_cnt <= '0;
    end else begin
      if (cs_up && ph == PH_WAIT) wel <= wen_op;
      if (accept) begin
        wip      <= 1'b1;
        busy_cnt <= BW'(BUSY_CYC - 1);
        pend_sr  <= sr_req;
        pend_val <= sr_wdata;
      end else if (wip) begin
        if (busy_cnt == '0) begin
          wip <= 1'b0;
          wel <= 1'b0;
          if (pend_sr) {srwd, bp} <= pend_val;
        end else
          busy_cnt <= busy_cnt - 1'b1;
      end
    end

  AST_OE_OFF_DESEL: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> !miso_oe); // R5
  AST_OE_OFF_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n) (ph == PH_CMD) |-> !miso_oe); // R5
  AST_ACCEPT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n) $rose(wip) |-> $past(wel)); // R8
  AST_END_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n) $fell(wip) |-> !wel); // R9
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (wip && busy_cnt != '0) |=> wip); // R9
  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) (!cs_n && !sck_fall && miso_oe) |=> $stable(miso)); // R11
endmodule

// File: tb/sim_sflash_stat_id_resp.sv
`timescale 1ns/1ps
module sim_sflash_stat_id_resp;
  localparam int H = 4;
  localparam int BUSY = 200;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic wr_req = 0, sr_req = 0;
  logic [3:0] sr_wdata = 0;
  logic miso, miso_oe;
  int nchk = 0, nerr = 0;
  logic [7:0] rxb [0:7];
  logic any_oe, cmd_oe, unstable;
  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t exp_q[$];
  logic [7:0] got_q[$];

  always #4 clk = ~clk;

  sflash_stat_id_resp #(.MFR_ID(8'h5A), .DEV_ID(16'hB3C4), .BUSY_CYC(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .wr_req(wr_req), .sr_req(sr_req), .sr_wdata(sr_wdata));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    exp_q.push_back(e);
  endtask

  always @(negedge clk)
    if (exp_q.size() > 0 && got_q.size() > 0) begin
      exp_t e;
      logic [7:0] g;
      e = exp_q.pop_front();
      g = got_q.pop_front();
      check(g == e.v, e.tag, {24'd0, g}, {24'd0, e.v});
    end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b);
    mosi = b; wclk(H);
    sclk = 1; wclk(H);
    sclk = 0;
  endtask

  task automatic spi_cmd(input logic [7:0] op, input int nclk);
    cs_n = 0; wclk(H);
    for (int i = 0; i < nclk; i++) clock_bit(i < 8 ? op[7-i] : 1'b0);
    wclk(H); cs_n = 1; wclk(2*H);
  endtask

  task automatic spi_read(input logic [7:0] op, input int nrx, input int extra, input bit sb);
    logic [7:0] v;
    logic m0;
    any_oe = 0; cmd_oe = 0;
    cs_n = 0; wclk(H);
    for (int i = 0; i < 8; i++) begin
      mosi = op[7-i]; wclk(H);
      if (miso_oe) cmd_oe = 1;
      sclk = 1; wclk(H); sclk = 0;
    end
    for (int b = 0; b < nrx + 1; b++) begin
      if (b == nrx && extra == 0) break;
      v = 0;
      for (int k = 0; k < (b == nrx ? extra : 8); k++) begin
        mosi = 0; wclk(H);
        v = {v[6:0], miso};
        if (miso_oe) any_oe = 1;
        sclk = 1; m0 = miso; wclk(H);
        if (miso_oe && miso != m0) unstable = 1;
        sclk = 0;
      end
      if (b < nrx) begin
        rxb[b] = v;
        if (sb) got_q.push_back(v);
      end
    end
    wclk(H); cs_n = 1; wclk(2*H);
    check(!cmd_oe, "R5 oe during instruction", {31'd0, cmd_oe}, 0);
  endtask

  task automatic pulse_req(input bit srw, input logic [3:0] d);
    @(negedge clk);
    wr_req = !srw; sr_req = srw; sr_wdata = d;
    @(negedge clk);
    wr_req = 0; sr_req = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int trans;
    unstable = 0;
    wclk(10); rst_n = 1; wclk(4);
    check(miso_oe == 0, "R1 oe after reset", {31'd0, miso_oe}, 0);
    expect_byte(8'h00, "R1 reset status"); expect_byte(8'h00, "R2 repeated status");
    spi_read(8'h05, 2, 0, 1);
    spi_cmd(8'h06, 8);
    expect_byte(8'h02, "R6 latch set"); spi_read(8'h05, 1, 0, 1);
    spi_cmd(8'h04, 8);
    expect_byte(8'h00, "R6 latch cleared"); spi_read(8'h05, 1, 0, 1);
    spi_cmd(8'h06, 7);
    expect_byte(8'h00, "R6 short frame ignored"); spi_read(8'h05, 1, 0, 1);
    spi_cmd(8'h06, 9);
    expect_byte(8'h00, "R6 long frame ignored"); spi_read(8'h05, 1, 0, 1);
    expect_byte(8'h5A, "R4 manufacturer"); expect_byte(8'hB3, "R4 device hi");
    expect_byte(8'hC4, "R4 device lo"); expect_byte(8'h00, "R4 trailing zero");
    spi_read(8'h9F, 4, 0, 1);
    spi_read(8'hAB, 2, 0, 0);
    check(!any_oe, "R7 unknown opcode drives output", {31'd0, any_oe}, 0);
    expect_byte(8'h00, "R7 status unchanged"); spi_read(8'h05, 1, 0, 1);
    pulse_req(0, 4'h0); wclk(5);
    expect_byte(8'h00, "R8 request without latch ignored"); spi_read(8'h05, 1, 0, 1);
    spi_cmd(8'h06, 8);
    pulse_req(1, 4'b1101); wclk(2);
    pulse_req(1, 4'b0110);
    expect_byte(8'h03, "R9 busy visible"); spi_read(8'h05, 1, 0, 1);
    wclk(BUSY + 20);
    expect_byte(8'h94, "R9 status write applied, R8 second request ignored");
    spi_read(8'h05, 1, 0, 1);
    spi_cmd(8'h06, 8);
    pulse_req(0, 4'h0);
    spi_read(8'h05, 8, 0, 0);
    check(rxb[0] == 8'h97, "R3 first polled byte busy", {24'd0, rxb[0]}, 32'h97);
    check(rxb[7] == 8'h94, "R3 last polled byte idle", {24'd0, rxb[7]}, 32'h94);
    trans = 0;
    for (int i = 1; i < 8; i++) if (rxb[i] != rxb[i-1]) trans++;
    check(trans == 1, "R3 single busy-to-idle change", trans, 1);
    spi_read(8'h05, 0, 4, 0);
    check(any_oe, "R10 abort read drove output", {31'd0, any_oe}, 1);
    expect_byte(8'h5A, "R10 fresh instruction after abort"); spi_read(8'h9F, 1, 0, 1);
    check(miso_oe == 0, "R5 oe with chip select high", {31'd0, miso_oe}, 0);
    check(!unstable, "R11 output changed outside falling edge", {31'd0, unstable}, 0);
    wclk(10);
    check(exp_q.size() == 0 && got_q.size() == 0, "R2 scoreboard drained",
          exp_q.size() + got_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule